// File: doc/BRIEF.md
# Latched Beam Position Byte Reader

This block returns two latched 9-bit beam positions, one horizontal and one vertical, through an 8-bit read port. Every position has its own byte-select flag, so successive reads of the same axis alternate between the low byte and the high byte. The high byte holds only the single upper position bit. Its remaining bits are filled from the current value of the shared open-bus latch, which the surrounding logic holds.

Every byte the block returns is offered back as an update for that latch. A read of the status register puts both byte-select flags back to the low-byte state. Capturing the counters and generating the beam position are handled elsewhere. A read access starts on the rising edge of a read strobe, so a strobe held high for several cycles counts as one access.

Top module: `beam_pos_byte_reader`

## Requirements
- R1: After a synchronous active-low reset, both byte-select flags are clear, so the first read of either axis returns the low byte.
- R2: When the axis flag is clear, an access returns position bits 7:0 on `rd_data` in the cycle the strobe rises, and then sets the flag.
- R3: When the axis flag is set, an access returns position bit 8 in bit 0 and `bus_latch` bits 7:1 in bits 7:1, and then clears the flag.
- R4: `latch_we` is high only in an access cycle, with `latch_val` equal to the returned byte. Outside an access, `rd_data` and `latch_we` are 0.
- R5: The horizontal and vertical flags are independent. An access on one axis leaves the other axis's flag unchanged.
- R6: A status read (`rd_stat` high) clears both flags. This overrides the flag change of a position access in the same cycle, although that access still returns its byte.
- R7: A strobe held high for more than one cycle changes its flag once and returns data only in its first cycle.
- R8: If both position strobes rise in the same cycle, the horizontal access is served, and the vertical flag and output are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_pos | input | 9 | Latched horizontal position |
| v_pos | input | 9 | Latched vertical position |
| rd_h | input | 1 | Horizontal position read strobe |
| rd_v | input | 1 | Vertical position read strobe |
| rd_stat | input | 1 | Status register read strobe |
| bus_latch | input | 8 | Current open-bus latch value |
| rd_data | output | 8 | Byte returned by the access |
| latch_we | output | 1 | Open-bus latch update enable |
| latch_val | output | 8 | New open-bus latch value |

## Verification
The bench builds the block with its default widths: a 9-bit position on an 8-bit port, so the high byte carries exactly one position bit and seven open-bus bits. This setting makes it possible to check the position bit and the open-bus fill separately. The positions used have bit 8 both set and clear, and the latch values use alternating bit patterns. Both flags are driven through every sequence of accesses: an axis read on its own, interleaved reads of the two axes, a status read on its own, a status read together with a position read, simultaneous strobes, and a held strobe.

// File: rtl/beam_pos_pkg.sv
// Package: shared axis indices for the beam position byte reader.
// Assumes exactly two axes, with horizontal first.
package beam_pos_pkg;
    localparam int NUM_AXES = 2;
    typedef enum int {
        AXIS_H = 0,
        AXIS_V = 1
    } axis_e;
endpackage

// File: rtl/strobe_rise.sv
// Module: strobe_rise
// Turns a level strobe into a single-cycle access pulse on its rising edge.
// Assumes the strobe is synchronous to clk.
module strobe_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev_q;

    // Remember the previous strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // The pulse is high while the strobe is high and was low in the previous cycle.
    always_comb rise = level & ~prev_q;
endmodule

// File: rtl/byte_select_flag.sv
// Module: byte_select_flag
// Holds the low/high byte-select flag of one axis.
// Assumes that clear takes priority over flip.
module byte_select_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    input  logic clear,
    output logic flag
);
    // Clear on reset or on a status read; otherwise flip on an access.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag <= 1'b0;
        else if (clear) flag <= 1'b0;
        else if (flip)  flag <= ~flag;
    end
endmodule

// File: rtl/pos_byte_mux.sv
// Module: pos_byte_mux
// Selects the low or high byte of a position.
// The high byte fills the bits above the position's top bits from the open-bus value.
// Assumes DATA_W < POS_W <= 2*DATA_W.
module pos_byte_mux #(
    parameter int POS_W  = 9,
    parameter int DATA_W = 8
) (
    input  logic [POS_W-1:0]  pos,
    input  logic              hi_sel,
    input  logic [DATA_W-1:0] bus_latch,
    output logic [DATA_W-1:0] byte_out
);
    localparam int HI_W = POS_W - DATA_W;

    logic [DATA_W-1:0] hi_byte;

    // Build the high byte: the position's top bits sit at the bottom, open-bus bits above.
    always_comb begin
        hi_byte = bus_latch;
        hi_byte[HI_W-1:0] = pos[POS_W-1:DATA_W];
    end

    // Choose the byte given by the flag.
    always_comb byte_out = hi_sel ? hi_byte : pos[DATA_W-1:0];
endmodule

// File: rtl/beam_pos_byte_reader.sv
// Module: beam_pos_byte_reader
// Byte-serial read port for the latched horizontal and vertical beam positions.
// Each axis alternates between its low and high byte. A status read clears both flags.
// The returned byte is offered as an update for the open-bus latch.
// Assumes all strobes are synchronous to clk and the latch is held outside this block.
module beam_pos_byte_reader #(
    parameter int POS_W  = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [POS_W-1:0]  h_pos,
    input  logic [POS_W-1:0]  v_pos,
    input  logic              rd_h,
    input  logic              rd_v,
    input  logic              rd_stat,
    input  logic [DATA_W-1:0] bus_latch,
    output logic [DATA_W-1:0] rd_data,
    output logic              latch_we,
    output logic [DATA_W-1:0] latch_val
);
    import beam_pos_pkg::*;

    logic [NUM_AXES-1:0] strobe;
    logic [NUM_AXES-1:0] rise;
    logic [NUM_AXES-1:0] access;
    logic [NUM_AXES-1:0] flag;
    logic [POS_W-1:0]    pos_arr  [NUM_AXES];
    logic [DATA_W-1:0]   byte_arr [NUM_AXES];
    logic                tog_h;
    logic                tog_v;

    // Gather the per-axis inputs into arrays.
    always_comb begin
        strobe[AXIS_H]  = rd_h;
        strobe[AXIS_V]  = rd_v;
        pos_arr[AXIS_H] = h_pos;
        pos_arr[AXIS_V] = v_pos;
    end

    // Apply the priority: horizontal wins when both strobes rise together.
    always_comb begin
        access[AXIS_H] = rise[AXIS_H];
        access[AXIS_V] = rise[AXIS_V] & ~rise[AXIS_H];
    end

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        strobe_rise u_rise (
            .clk   (clk),
            .rst_n (rst_n),
            .level (strobe[a]),
            .rise  (rise[a])
        );

        byte_select_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .flip  (access[a]),
            .clear (rd_stat),
            .flag  (flag[a])
        );

        pos_byte_mux #(.POS_W(POS_W), .DATA_W(DATA_W)) u_mux (
            .pos       (pos_arr[a]),
            .hi_sel    (flag[a]),
            .bus_latch (bus_latch),
            .byte_out  (byte_arr[a])
        );
    end

    // Drive the read port and the open-bus update from the served axis.
    always_comb begin
        rd_data = '0;
        if (access[AXIS_H])      rd_data = byte_arr[AXIS_H];
        else if (access[AXIS_V]) rd_data = byte_arr[AXIS_V];
        latch_we  = |access;
        latch_val = rd_data;
        tog_h     = flag[AXIS_H];
        tog_v     = flag[AXIS_V];
    end
endmodule

// File: rtl/beam_pos_byte_reader_chk.sv
// Module: beam_pos_byte_reader_chk
// Property checker for beam_pos_byte_reader, attached with bind.
// Assumes the default widths of one high position bit.
module beam_pos_byte_reader_chk #(
    parameter int POS_W  = 9,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_h,
    input logic              rd_v,
    input logic              rd_stat,
    input logic [POS_W-1:0]  h_pos,
    input logic [DATA_W-1:0] bus_latch,
    input logic [DATA_W-1:0] rd_data,
    input logic              latch_we,
    input logic              tog_h,
    input logic              tog_v
);
    logic past_valid;

    // Mark the cycles after the first cycle out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    AST_WE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        latch_we |-> (rd_h || rd_v)); // R4

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_we |-> (rd_data == '0)); // R4

    AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (!tog_h && !tog_v)); // R6

    AST_H_LOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && rd_h && !$past(rd_h) && !rd_stat && !tog_h) |=> tog_h); // R2

    AST_H_HIGH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && rd_h && !$past(rd_h) && tog_h)
            |-> (rd_data[DATA_W-1:1] == bus_latch[DATA_W-1:1] && rd_data[0] == h_pos[DATA_W])); // R3

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && rd_h && $past(rd_h) && !rd_stat) |=> $stable(tog_h)); // R7

    AST_V_IGNORED_ON_TIE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && rd_h && !$past(rd_h) && !rd_stat) |=> $stable(tog_v)); // R8
endmodule

bind beam_pos_byte_reader beam_pos_byte_reader_chk #(.POS_W(POS_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_h      (rd_h),
    .rd_v      (rd_v),
    .rd_stat   (rd_stat),
    .h_pos     (h_pos),
    .bus_latch (bus_latch),
    .rd_data   (rd_data),
    .latch_we  (latch_we),
    .tog_h     (tog_h),
    .tog_v     (tog_v)
);

// File: tb/beam_pos_byte_reader_tb.sv
module beam_pos_byte_reader_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] h_pos = 9'h1C3;
    logic [8:0] v_pos = 9'h0A7;
    logic       rd_h = 1'b0;
    logic       rd_v = 1'b0;
    logic       rd_stat = 1'b0;
    logic [7:0] bus_latch = 8'hA5;
    logic [7:0] rd_data;
    logic       latch_we;
    logic [7:0] latch_val;

    int checks = 0;
    int errors = 0;
    bit th = 1'b0;
    bit tv = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    beam_pos_byte_reader u_dut (
        .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .v_pos(v_pos),
        .rd_h(rd_h), .rd_v(rd_v), .rd_stat(rd_stat), .bus_latch(bus_latch),
        .rd_data(rd_data), .latch_we(latch_we), .latch_val(latch_val)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [8:0] p, input bit hi);
        return hi ? {bus_latch[7:1], p[8]} : p[7:0];
    endfunction

    // One access: raise strobes at a falling edge, check before the rising edge, release.
    task automatic access(input bit h, input bit v, input bit s, input string req);
        logic [7:0] e;
        bit we;
        @(negedge clk);
        rd_h = h; rd_v = v; rd_stat = s;
        #2;
        we = h | v;
        e  = h ? exp_byte(h_pos, th) : (v ? exp_byte(v_pos, tv) : 8'h00);
        check(req, {1'b0, rd_data}, {1'b0, e});
        check(req, {8'h00, latch_we}, {8'h00, we});
        check(req, {1'b0, latch_val}, {1'b0, e});
        if (s) begin th = 0; tv = 0; end
        else if (h) th = ~th;
        else if (v) tv = ~tv;
        @(negedge clk);
        rd_h = 0; rd_v = 0; rd_stat = 0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 idle data", {1'b0, rd_data}, 9'h000);
        check("R1 idle we", {8'h00, latch_we}, 9'h000);
        access(1, 0, 0, "R1 R2 first h low");
        access(0, 1, 0, "R1 R5 first v low");
    endtask

    task automatic t_alternate;
        access(1, 0, 0, "R3 h high bit8=1");
        access(1, 0, 0, "R2 h low again");
        bus_latch = 8'h5A;
        access(1, 0, 0, "R3 h high new latch");
        access(0, 1, 0, "R3 R5 v high bit8=0");
        v_pos = 9'h17E;
        access(0, 1, 0, "R2 v low");
        access(0, 1, 0, "R3 v high bit8=1");
    endtask

    task automatic t_status;
        access(1, 0, 0, "R2 h low before stat");
        access(0, 1, 0, "R5 v low before stat");
        access(0, 0, 1, "R6 stat alone");
        access(1, 0, 0, "R6 h low after stat");
        access(1, 0, 1, "R6 h high with stat");
        access(1, 0, 0, "R6 h low after stat+read");
        access(0, 0, 1, "R6 clear");
    endtask

    task automatic t_held;
        @(negedge clk);
        rd_h = 1;
        #2;
        check("R7 held first", {1'b0, rd_data}, {1'b0, exp_byte(h_pos, 0)});
        @(negedge clk);
        #2;
        check("R7 held data", {1'b0, rd_data}, 9'h000);
        check("R7 held we", {8'h00, latch_we}, 9'h000);
        @(negedge clk);
        rd_h = 0;
        th = 1;
        access(1, 0, 0, "R7 next is high");
    endtask

    task automatic t_priority;
        access(0, 1, 0, "R8 v low sets");
        access(1, 1, 0, "R8 tie serves h low");
        access(0, 1, 0, "R8 v still high");
        access(1, 0, 0, "R8 h high after tie");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_alternate();
        t_status();
        t_held();
        t_priority();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule